// File: doc/BRIEF.md
# Buffered SPI Slave Interface

This block is an SPI slave attached to a small register bus. It never drives the serial clock. It takes SCK, MOSI and the chip-select line from an external master, re-times them into the system clock domain and moves one word at a time through a shift engine.

A single transmit buffer and a single receive buffer sit between the register bus and the shift engine. Two handshake flags govern them: transmit-empty (TXE) and receive-not-empty (RXNE). A third flag, overrun (OVR), records a completed frame that found the receive buffer still full. The interrupt line combines TXE and RXNE, each gated by its own enable.

Software can change all of the following at run time: clock polarity and phase (all four modes), frame width (8 or 16 bits), bit order, and the select source (the pin, or a control bit).

Top module: `spi_slave_buf`

## Requirements
- R1: After reset the status register (address 1) reads 0x0002: RXNE at bit 0 is 0, TXE at bit 1 is 1 and OVR at bit 2 is 0. The interrupt output is low.
- R2: The control register is at address 0. Its bits are: 0 phase, 1 polarity, 2 LSB-first, 3 16-bit frame, 4 software select, 5 software select level (0 = selected), 6 enable, 7 TXE interrupt enable, 8 RXNE interrupt enable. In all four polarity/phase modes an 8-bit MSB-first frame is exchanged full-duplex. The master receives the low byte of the transmit buffer, and the slave receives the master's byte.
- R3: With bit 3 set, a frame carries 16 bits in both directions.
- R4: With bit 2 set, the least significant bit goes first, for both the sent and the received word.
- R5: With software select on, the select level bit replaces the pin and the pin is ignored. Level 1 leaves the slave unselected, so a frame yields no RXNE.
- R6: A write to the data register (address 2) loads the transmit buffer and clears TXE. TXE is set again when a frame starts and the buffer is moved into the shifter.
- R7: After the last sampling edge of a frame, the received word enters the receive buffer and RXNE is set. A data read returns that word and clears RXNE.
- R8: A frame that completes while RXNE is set sets OVR and leaves the receive buffer unchanged. A status read followed by a data read clears OVR.
- R9: If TXE is still set when a frame starts, the previously transmitted word is sent again.
- R10: Deselecting in the middle of a frame discards the partial frame and resets the bit count, so the next frame is received aligned.
- R11: The interrupt output is high exactly when (TXE and its enable) or (RXNE and its enable).
- R12: With the enable bit clear, the slave ignores all serial traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address (0 control, 1 status, 2 data) |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (enables read side effects) |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for addr_i |
| irq_o | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data in |
| nss_i | input | 1 | Select pin, active low |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | High while the slave is selected and enabled |

## Verification
The hardest states to reach are the ones where the serial side and the register side collide. One is overrun: a second frame has to complete before software reads the first word. The other is a frame that is abandoned after a few bits and then restarted. The bench creates overrun by running two back-to-back master frames with no data read between them, and then checks both the stale buffer contents and the two-step clear. It creates the abandoned frame by raising the select pin after three clock periods, and then checks that a following full frame is received aligned in both directions.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  typedef struct packed {
    logic rxne_ie;
    logic txe_ie;
    logic en;
    logic sw_lvl;
    logic sw_sel;
    logic wide;
    logic lsb;
    logic cpol;
    logic cpha;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[s] <= RST_VAL;
        else         stg[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[s] <= RST_VAL;
        else         stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core import spi_slave_pkg::*; #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          sck_i,
  input  logic          mosi_i,
  input  ctrl_t         ctrl_i,
  input  logic [DW-1:0] tx_word_i,
  output logic          load_o,
  output logic          done_o,
  output logic [DW-1:0] rx_word_o,
  output logic          miso_o
);
  localparam int HALF = DW / 2;
  localparam int CW = $clog2(DW);
  localparam logic [DW-1:0] HALF_MASK = {{(DW-HALF){1'b0}}, {HALF{1'b1}}};

  logic          sck_q, loaded;
  logic [CW-1:0] cnt, last;
  logic [DW-1:0] tx_sh, rx_sh, rx_nxt;
  logic          edge_s, lead_e, trail_e, sample_e, shift_e;

  assign edge_s   = sck_i ^ sck_q;
  assign lead_e   = edge_s && (sck_i != ctrl_i.cpol);
  assign trail_e  = edge_s && (sck_i == ctrl_i.cpol);
  assign sample_e = ctrl_i.cpha ? trail_e : lead_e;
  assign shift_e  = ctrl_i.cpha ? lead_e : trail_e;
  assign last     = ctrl_i.wide ? CW'(DW-1) : CW'(HALF-1);

  assign rx_nxt = ctrl_i.lsb ? {mosi_i, rx_sh[DW-1:1]} : {rx_sh[DW-2:0], mosi_i};
  always_comb begin
    if (ctrl_i.wide)     rx_word_o = rx_nxt;
    else if (ctrl_i.lsb) rx_word_o = rx_nxt >> HALF;
    else                 rx_word_o = rx_nxt & HALF_MASK;
  end

  assign miso_o = ctrl_i.lsb  ? tx_sh[0] :
                  ctrl_i.wide ? tx_sh[DW-1] : tx_sh[HALF-1];

  assign load_o = sel_i && !loaded;
  assign done_o = sel_i && loaded && sample_e && (cnt == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q  <= 1'b0;
      loaded <= 1'b0;
      cnt    <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
    end else begin
      sck_q <= sck_i;
      if (!sel_i) begin
        loaded <= 1'b0;
        cnt    <= '0;
      end else if (!loaded) begin
        tx_sh  <= tx_word_i;
        loaded <= 1'b1;
        cnt    <= '0;
      end else begin
        // first shift edge of a frame keeps the bit presented at load
        if (shift_e && cnt != '0)
          tx_sh <= ctrl_i.lsb ? (tx_sh >> 1) : (tx_sh << 1);
        if (sample_e) begin
          rx_sh <= rx_nxt;
          if (cnt == last) begin
            cnt    <= '0;
            loaded <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  a_r10_desel_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> (cnt == '0 && !loaded));
  a_r6_single_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);
  a_r7_done_ends_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (cnt == '0));
endmodule

// File: rtl/spi_regif.sv
module spi_regif import spi_slave_pkg::*; #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    addr_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          load_i,
  input  logic          done_i,
  input  logic [DW-1:0] rx_word_i,
  output ctrl_t         ctrl_o,
  output logic [DW-1:0] tx_word_o,
  output logic          irq_o
);
  logic          txe, rxne, ovr, stat_seen;
  logic [DW-1:0] rx_buf;
  logic          data_wr, data_rd, stat_rd;

  assign data_wr = wr_en_i && addr_i == ADDR_DATA;
  assign data_rd = rd_en_i && addr_i == ADDR_DATA;
  assign stat_rd = rd_en_i && addr_i == ADDR_STAT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o    <= '0;
      tx_word_o <= '0;
      rx_buf    <= '0;
      txe       <= 1'b1;
      rxne      <= 1'b0;
      ovr       <= 1'b0;
      stat_seen <= 1'b0;
    end else begin
      if (wr_en_i && addr_i == ADDR_CTRL) ctrl_o <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (load_i) txe <= 1'b1;
      if (data_wr) begin
        tx_word_o <= wdata_i;
        txe       <= 1'b0;
      end
      if (stat_rd && ovr) stat_seen <= 1'b1;
      if (data_rd) begin
        rxne <= 1'b0;
        if (stat_seen) begin
          ovr       <= 1'b0;
          stat_seen <= 1'b0;
        end
      end
      if (done_i) begin
        if (rxne && !data_rd) begin
          ovr <= 1'b1;
        end else begin
          rx_buf <= rx_word_i;
          rxne   <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_CTRL: rdata_o = {{(DW-CTRL_W){1'b0}}, ctrl_o};
      ADDR_STAT: rdata_o = {{(DW-3){1'b0}}, ovr, txe, rxne};
      ADDR_DATA: rdata_o = rx_buf;
      default:   rdata_o = '0;
    endcase
  end

  assign irq_o = (txe && ctrl_o.txe_ie) || (rxne && ctrl_o.rxne_ie);

  a_r6_txe_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !data_wr) |=> txe);
  a_r6_write_clears_txe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr |=> !txe);
  a_r7_rxne_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !rxne) |=> (rxne && rx_buf == $past(rx_word_i)));
  a_r7_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && !done_i) |=> !rxne);
  a_r8_ovr_keeps_buf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && rxne && !data_rd) |=> (ovr && $stable(rx_buf)));
endmodule

// File: rtl/spi_slave_buf.sv
module spi_slave_buf import spi_slave_pkg::*; #(
  parameter int DW = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    addr_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  input  logic          sck_i,
  input  logic          mosi_i,
  input  logic          nss_i,
  output logic          miso_o,
  output logic          miso_oe_o
);
  ctrl_t         ctrl;
  logic [DW-1:0] tx_word, rx_word;
  logic          load, done, sel;
  logic          sck_s, mosi_s, nss_s;

  spi_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({nss_i, mosi_i, sck_i}),
    .q_o   ({nss_s, mosi_s, sck_s})
  );

  assign sel = ctrl.en && (ctrl.sw_sel ? !ctrl.sw_lvl : !nss_s);
  assign miso_oe_o = sel;

  spi_shift_core #(.DW(DW)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel),
    .sck_i    (sck_s),
    .mosi_i   (mosi_s),
    .ctrl_i   (ctrl),
    .tx_word_i(tx_word),
    .load_o   (load),
    .done_o   (done),
    .rx_word_o(rx_word),
    .miso_o   (miso_o)
  );

  spi_regif #(.DW(DW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .load_i   (load),
    .done_i   (done),
    .rx_word_i(rx_word),
    .ctrl_o   (ctrl),
    .tx_word_o(tx_word),
    .irq_o    (irq_o)
  );

  a_r12_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.en |-> (!load && !done));
  a_r5_sw_level_deselects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.sw_sel && ctrl.sw_lvl) |-> !miso_oe_o);
endmodule

// File: tb/spi_slave_buf_bench.sv
module spi_slave_buf_bench;
  localparam int H = 6;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wdata = '0, rdata;
  logic        irq, sck = 1'b0, mosi = 1'b0, nss = 1'b1, miso, miso_oe;
  int          total = 0, bad = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  spi_slave_buf u_spi_slave_buf (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .sck_i(sck), .mosi_i(mosi),
    .nss_i(nss), .miso_o(miso), .miso_oe_o(miso_oe)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  function automatic logic [15:0] mk(input bit cpol, cpha, lsb, wide, swsel, swlvl, en, txie, rxie);
    return {7'd0, rxie, txie, en, swlvl, swsel, wide, lsb, cpol, cpha};
  endfunction

  task automatic mxfer(input int nb, input bit cpol, cpha, lsb,
                       input logic [15:0] mo, output logic [15:0] mi);
    mi = '0;
    for (int i = 0; i < nb; i++) begin
      int idx = lsb ? i : nb - 1 - i;
      if (!cpha) begin
        mosi = mo[idx]; cyc(H);
        sck = ~cpol; mi[idx] = miso; cyc(H);
        sck = cpol;
      end else begin
        cyc(H); sck = ~cpol; mosi = mo[idx]; cyc(H);
        sck = cpol; mi[idx] = miso;
      end
    end
    cyc(H);
  endtask

  // hardware-select frame with the full flag/data checks
  task automatic hw_frame(input string req, input bit cpol, cpha, lsb, wide,
                          input logic [15:0] stx, mtx);
    logic [15:0] d, mi, msk;
    int nb = wide ? 16 : 8;
    msk = wide ? 16'hFFFF : 16'h00FF;
    sck = cpol; cyc(4);
    reg_wr(0, mk(cpol, cpha, lsb, wide, 0, 0, 1, 0, 0));
    reg_wr(2, stx);
    reg_rd(1, d); chk({req, " R6 txe clear"}, d & 16'h2, 16'h0);
    @(negedge clk); nss = 1'b0; cyc(8);
    mxfer(nb, cpol, cpha, lsb, mtx, mi);
    nss = 1'b1; cyc(6);
    chk({req, " master rx"}, mi & msk, stx & msk);
    reg_rd(1, d); chk({req, " R6/R7 status"}, d, 16'h0003);
    reg_rd(2, d); chk({req, " R7 rx data"}, d, mtx & msk);
    reg_rd(1, d); chk({req, " R7 rxne clear"}, d, 16'h0002);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    reg_rd(1, d); chk("R1 status", d, 16'h0002);
    chk("R1 irq", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_modes;
    hw_frame("R2 mode0", 0, 0, 0, 0, 16'h00A5, 16'h003C);
    hw_frame("R2 mode1", 0, 1, 0, 0, 16'h0096, 16'h00E1);
    hw_frame("R2 mode2", 1, 0, 0, 0, 16'h004B, 16'h0072);
    hw_frame("R2 mode3", 1, 1, 0, 0, 16'h00D2, 16'h0019);
  endtask

  task automatic t_wide;
    hw_frame("R3 16bit m0", 0, 0, 0, 1, 16'h1234, 16'hBEEF);
    hw_frame("R3 16bit m3", 1, 1, 0, 1, 16'hC0DE, 16'h8001);
  endtask

  task automatic t_lsb;
    hw_frame("R4 lsb 8", 0, 0, 1, 0, 16'h0081, 16'h0006);
    hw_frame("R4 lsb 16", 0, 1, 1, 1, 16'h8421, 16'h1F00);
  endtask

  task automatic t_swsel;
    logic [15:0] d, mi;
    sck = 0; nss = 1'b1;
    reg_wr(0, mk(0, 0, 0, 0, 1, 1, 1, 0, 0));
    reg_wr(2, 16'h005A);
    cyc(8);
    mxfer(8, 0, 0, 0, 16'h00C3, mi);
    reg_rd(1, d); chk("R5 sw level 1 no rx", d & 16'h1, 16'h0);
    reg_wr(0, mk(0, 0, 0, 0, 1, 0, 1, 0, 0));
    cyc(8);
    mxfer(8, 0, 0, 0, 16'h00C3, mi);
    cyc(4);
    chk("R5 sw select master rx", mi & 16'hFF, 16'h005A);
    reg_rd(2, d); chk("R5 sw select rx", d, 16'h00C3);
    reg_wr(0, mk(0, 0, 0, 0, 0, 0, 1, 0, 0));
  endtask

  task automatic t_repeat;
    logic [15:0] d, mi;
    hw_frame("R9 prime", 0, 0, 0, 0, 16'h0077, 16'h0011);
    nss = 1'b0; cyc(8);
    mxfer(8, 0, 0, 0, 16'h0022, mi);
    nss = 1'b1; cyc(6);
    chk("R9 resend", mi & 16'hFF, 16'h0077);
    reg_rd(1, d); chk("R9 txe stays set", d, 16'h0003);
    reg_rd(2, d); chk("R9 rx data", d, 16'h0022);
  endtask

  task automatic t_ovr;
    logic [15:0] d, mi;
    reg_wr(0, mk(0, 0, 0, 0, 0, 0, 1, 0, 0));
    reg_wr(2, 16'h0001);
    nss = 1'b0; cyc(8); mxfer(8, 0, 0, 0, 16'h00AA, mi); nss = 1'b1; cyc(8);
    nss = 1'b0; cyc(8); mxfer(8, 0, 0, 0, 16'h0055, mi); nss = 1'b1; cyc(6);
    reg_rd(1, d); chk("R8 ovr set", d, 16'h0007);
    reg_rd(2, d); chk("R8 buffer kept", d, 16'h00AA);
    reg_rd(1, d); chk("R8 ovr cleared", d, 16'h0002);
  endtask

  task automatic t_abort;
    logic [15:0] d, mi;
    reg_wr(0, mk(0, 0, 0, 0, 0, 0, 1, 0, 0));
    reg_wr(2, 16'h00B4);
    nss = 1'b0; cyc(8);
    mxfer(3, 0, 0, 0, 16'h0007, mi);
    nss = 1'b1; cyc(8);
    reg_rd(1, d); chk("R10 partial no rxne", d & 16'h1, 16'h0);
    nss = 1'b0; cyc(8);
    mxfer(8, 0, 0, 0, 16'h00E7, mi);
    nss = 1'b1; cyc(6);
    chk("R10 master rx aligned", mi & 16'hFF, 16'h00B4);
    reg_rd(2, d); chk("R10 rx aligned", d, 16'h00E7);
  endtask

  task automatic t_irq;
    logic [15:0] d, mi;
    reg_wr(0, mk(0, 0, 0, 0, 0, 0, 1, 0, 1));
    reg_wr(2, 16'h0033);
    cyc(2); chk("R11 irq idle", {15'd0, irq}, 16'h0);
    nss = 1'b0; cyc(8); mxfer(8, 0, 0, 0, 16'h0044, mi); nss = 1'b1; cyc(6);
    chk("R11 irq on rxne", {15'd0, irq}, 16'h1);
    reg_rd(2, d); cyc(1);
    chk("R11 irq off after read", {15'd0, irq}, 16'h0);
    reg_wr(0, mk(0, 0, 0, 0, 0, 0, 1, 1, 1));
    cyc(1); chk("R11 irq on txe", {15'd0, irq}, 16'h1);
  endtask

  task automatic t_disabled;
    logic [15:0] d, mi;
    reg_wr(0, mk(0, 0, 0, 0, 0, 0, 0, 0, 0));
    reg_wr(2, 16'h0099);
    nss = 1'b0; cyc(8); mxfer(8, 0, 0, 0, 16'h0066, mi); nss = 1'b1; cyc(6);
    reg_rd(1, d); chk("R12 disabled no rxne, txe untouched", d, 16'h0000);
  endtask

  initial begin
    cyc(3); rst_n = 1'b1; cyc(3);
    t_reset();
    t_modes();
    t_wide();
    t_lsb();
    t_swsel();
    t_repeat();
    t_ovr();
    t_abort();
    t_irq();
    t_disabled();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule